// File: doc/BRIEF.md
# Power Button and Power-Good Supervisor

This block sits between the board-level power switch, the platform power-good line and the platform reset line on one side, and the platform controller hub on the other. It forwards the power switch to a low-active button output only after a press has been confirmed by a second look taken a fixed time after the falling edge; releases are forwarded without delay. It raises two power-OK outputs in a staggered order while system power-good is high, and drops both of them in the same cycle as soon as power-good falls or the rail sequencer requests a forced shutdown. A rising edge on platform reset produces a one-cycle enable pulse for the peripheral logic that is brought up after reset.

All four inputs pass through two-flop synchronisers. Two Moore state machines do the work. The button machine has the states BTN_UP, BTN_WAIT and BTN_DOWN. Its transitions are: press-seen (BTN_UP to BTN_WAIT when the synchronised switch is low), confirm (BTN_WAIT to BTN_DOWN when the switch is still low at the end of the confirmation window), spurious (BTN_WAIT to BTN_UP when it is high at that point) and release (BTN_DOWN to BTN_UP when the switch reads high). The power-OK machine has the states POK_OFF, POK_STAGE and POK_ON. Its transitions are: good-seen (POK_OFF to POK_STAGE when power-good is high and no force is requested), stagger-done (POK_STAGE to POK_ON when the stagger counter expires), and drop (either POK_STAGE or POK_ON back to POK_OFF when power-good is low or force is high). A small edge detector produces the enable pulse.

Top module: `pwrsup_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, pwr_btn_no is 1 and core_pok_o, sys_pok_o and periph_en_o are 0.
- R2: Every input passes through a two-flop synchroniser, so an input change made between clock edges reaches the state machines after two edges and shows on an output at the third edge after the change.
- R3: After pwr_sw_ni falls and stays low, pwr_btn_no goes low at the (CONFIRM_CYC+3)th edge after the fall, provided the switch is still low when it is sampled at the end of the window.
- R4: A press whose switch level is high again when sampled at the end of the confirmation window is discarded: pwr_btn_no stays 1 throughout. For a low pulse of L cycles this happens exactly when L <= CONFIRM_CYC.
- R5: A release of pwr_sw_ni to 1 is forwarded without confirmation: pwr_btn_no returns to 1 at the third edge after the release.
- R6: core_pok_o rises at the third edge after sys_pg_i rises, when force_off_i is 0.
- R7: sys_pok_o rises STAGGER_CYC edges after core_pok_o rises, if power-good stays high; sys_pok_o is never 1 while core_pok_o is 0.
- R8: When sys_pg_i falls, core_pok_o and sys_pok_o both fall at the same edge, the third after the fall.
- R9: If power-good drops during the stagger, the stagger restarts from zero on the next rise: sys_pok_o then rises STAGGER_CYC+3 edges after that rise.
- R10: force_off_i = 1 drives both power-OK outputs low (at the third edge after it rises) and holds them low; after it is released with power-good high, the full stagger sequence runs again.
- R11: A rising edge of plat_rst_ni produces periph_en_o = 1 for exactly one cycle, at the third edge after the rise; a falling edge produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_sw_ni | input | 1 | Power switch, low when pressed (asynchronous) |
| sys_pg_i | input | 1 | System-wide power-good (asynchronous) |
| plat_rst_ni | input | 1 | Platform reset, low-active (asynchronous) |
| force_off_i | input | 1 | Force-low request from the rail sequencer |
| pwr_btn_no | output | 1 | Confirmed power-button level, low when pressed |
| core_pok_o | output | 1 | First power-OK output |
| sys_pok_o | output | 1 | Second (system) power-OK output |
| periph_en_o | output | 1 | One-cycle peripheral-enable pulse |

## Verification
Because every output is decoded directly from a state register, a wrong state or a wrong counter value becomes visible on a port in the very cycle it occurs. A button machine stuck in BTN_WAIT shows up as a missing press or a press that lasts too few cycles. A confirmation counter that is off by one moves the boundary pulse length at which presses are accepted and shifts the first low cycle by one. A stagger counter that is not cleared on a drop or a force shows up in the next power-up as sys_pok_o rising too early.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;

    typedef enum logic [1:0] {
        BTN_UP   = 2'd0,
        BTN_WAIT = 2'd1,
        BTN_DOWN = 2'd2
    } btn_state_e;

    typedef enum logic [1:0] {
        POK_OFF   = 2'd0,
        POK_STAGE = 2'd1,
        POK_ON    = 2'd2
    } pok_state_e;

    // synchroniser lane assignment
    localparam int unsigned LANE_SW    = 0;
    localparam int unsigned LANE_PG    = 1;
    localparam int unsigned LANE_PRST  = 2;
    localparam int unsigned LANE_FORCE = 3;
    localparam int unsigned LANES      = 4;

endpackage

// File: rtl/pwrsup_sync.sv
module pwrsup_sync #(
    parameter int unsigned         WIDTH   = 4,
    parameter int unsigned         STAGES  = 2,
    parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_lane
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                chain_q <= {STAGES{RST_VAL[b]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/pwrsup_button.sv
module pwrsup_button
    import pwrsup_pkg::*;
#(
    parameter int unsigned CONFIRM_CYC = 320000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sw_n_i,
    output logic btn_n_o
);

    localparam int unsigned CW = $clog2(CONFIRM_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CONFIRM_CYC - 1);

    btn_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= BTN_UP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            BTN_UP: begin
                cnt_d = '0;
                if (!sw_n_i) begin
                    st_d = BTN_WAIT;          // press-seen
                end
            end
            BTN_WAIT: begin
                if (cnt_q == LAST) begin
                    cnt_d = '0;
                    st_d  = sw_n_i ? BTN_UP   // spurious
                                   : BTN_DOWN; // confirm
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            BTN_DOWN: begin
                cnt_d = '0;
                if (sw_n_i) begin
                    st_d = BTN_UP;            // release
                end
            end
            default: begin
                st_d  = BTN_UP;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        btn_n_o = (st_q != BTN_DOWN);
    end

endmodule

// File: rtl/pwrsup_pok.sv
module pwrsup_pok
    import pwrsup_pkg::*;
#(
    parameter int unsigned STAGGER_CYC = 320000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pg_i,
    input  logic force_i,
    output logic pok1_o,
    output logic pok2_o
);

    localparam int unsigned CW = $clog2(STAGGER_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STAGGER_CYC - 1);

    pok_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          drop;

    assign drop = !pg_i || force_i;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= POK_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            POK_OFF: begin
                cnt_d = '0;
                if (!drop) begin
                    st_d = POK_STAGE;         // good-seen
                end
            end
            POK_STAGE: begin
                if (drop) begin
                    st_d  = POK_OFF;          // drop
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    st_d  = POK_ON;           // stagger-done
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            POK_ON: begin
                cnt_d = '0;
                if (drop) begin
                    st_d = POK_OFF;           // drop
                end
            end
            default: begin
                st_d  = POK_OFF;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        pok1_o = (st_q != POK_OFF);
        pok2_o = (st_q == POK_ON);
    end

endmodule

// File: rtl/pwrsup_rise.sv
module pwrsup_rise (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic pulse_o
);

    logic prev_q, pulse_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= lvl_i;
            pulse_q <= lvl_i && !prev_q;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/pwrsup_top.sv
module pwrsup_top
    import pwrsup_pkg::*;
#(
    parameter int unsigned CONFIRM_CYC = 320000,
    parameter int unsigned STAGGER_CYC = 320000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwr_sw_ni,
    input  logic sys_pg_i,
    input  logic plat_rst_ni,
    input  logic force_off_i,
    output logic pwr_btn_no,
    output logic core_pok_o,
    output logic sys_pok_o,
    output logic periph_en_o
);

    localparam logic [LANES-1:0] SYNC_RST = LANES'(1) << LANE_SW;

    logic [LANES-1:0] raw_in, sync_in;
    logic sw_s, pg_s, prst_s, force_s;

    always_comb begin
        raw_in             = '0;
        raw_in[LANE_SW]    = pwr_sw_ni;
        raw_in[LANE_PG]    = sys_pg_i;
        raw_in[LANE_PRST]  = plat_rst_ni;
        raw_in[LANE_FORCE] = force_off_i;
    end

    pwrsup_sync #(
        .WIDTH   (LANES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    assign sw_s    = sync_in[LANE_SW];
    assign pg_s    = sync_in[LANE_PG];
    assign prst_s  = sync_in[LANE_PRST];
    assign force_s = sync_in[LANE_FORCE];

    pwrsup_button #(
        .CONFIRM_CYC (CONFIRM_CYC)
    ) u_button (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sw_n_i  (sw_s),
        .btn_n_o (pwr_btn_no)
    );

    pwrsup_pok #(
        .STAGGER_CYC (STAGGER_CYC)
    ) u_pok (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pg_i    (pg_s),
        .force_i (force_s),
        .pok1_o  (core_pok_o),
        .pok2_o  (sys_pok_o)
    );

    pwrsup_rise u_rise (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .lvl_i   (prst_s),
        .pulse_o (periph_en_o)
    );

endmodule

// File: rtl/pwrsup_checker.sv
module pwrsup_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic sw_s,
    input logic pg_s,
    input logic force_s,
    input logic btn_n,
    input logic pok1,
    input logic pok2,
    input logic en
);

    // R7: second power-OK never without the first
    p_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pok2 |-> pok1)
        else $error("p_order_r7");

    // R8: the second output never falls on its own
    p_drop_together_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pok2) |-> $fell(pok1))
        else $error("p_drop_together_r8");

    // R10: a synchronised force request empties both outputs next cycle
    p_force_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_s |=> (!pok1 && !pok2))
        else $error("p_force_r10");

    // R6: the first output only rises after power-good was seen
    p_rise_needs_pg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pok1) |-> $past(pg_s))
        else $error("p_rise_needs_pg_r6");

    // R11: enable pulse is a single cycle
    p_single_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en |=> !en)
        else $error("p_single_pulse_r11");

    // R5: a high switch level releases the button next cycle
    p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!btn_n && sw_s) |=> btn_n)
        else $error("p_release_r5");

    // R3: a press is only forwarded on a low switch level
    p_press_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(btn_n) |-> !$past(sw_s))
        else $error("p_press_low_r3");

endmodule

bind pwrsup_top pwrsup_checker u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sw_s    (sw_s),
    .pg_s    (pg_s),
    .force_s (force_s),
    .btn_n   (pwr_btn_no),
    .pok1    (core_pok_o),
    .pok2    (sys_pok_o),
    .en      (periph_en_o)
);

// File: tb/pwrsup_top_test.sv
module pwrsup_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 8;   // confirmation window
    localparam int NS = 12;  // stagger window

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_n = 1'b1;
    logic pg = 1'b0;
    logic prst_n = 1'b0;
    logic force_off = 1'b0;
    logic btn_n, pok1, pok2, en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrsup_top #(
        .CONFIRM_CYC (NC),
        .STAGGER_CYC (NS),
        .SYNC_STAGES (2)
    ) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pwr_sw_ni   (sw_n),
        .sys_pg_i    (pg),
        .plat_rst_ni (prst_n),
        .force_off_i (force_off),
        .pwr_btn_no  (btn_n),
        .core_pok_o  (pok1),
        .sys_pok_o   (pok2),
        .periph_en_o (en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R3 R4 R5 R2: press of L cycles
    task automatic press_run(input int len);
        int first = -1;
        int lows = 0;
        int exp_cnt;
        @(negedge clk);
        sw_n = 1'b0;
        for (int i = 1; i <= len + NC + 10; i++) begin
            @(negedge clk);
            if (!btn_n) begin
                lows++;
                if (first < 0) first = i;
            end
            if (i == len) sw_n = 1'b1;
        end
        exp_cnt = (len >= NC + 1) ? len - NC : 0;
        chk(lows == exp_cnt, (exp_cnt == 0) ? "R4 spurious press low cycles" : "R5 press length", lows, exp_cnt);
        if (exp_cnt > 0)
            chk(first == NC + 3, "R3 R2 first low cycle", first, NC + 3);
    endtask

    // R6 R7 R8: power-good high for H cycles
    task automatic pg_run(input int hold);
        int f1 = -1, f2 = -1, c1 = 0, c2 = 0;
        bit bad = 1'b0;
        int exp2;
        @(negedge clk);
        pg = 1'b1;
        for (int i = 1; i <= hold + NS + 10; i++) begin
            @(negedge clk);
            if (pok1) begin c1++; if (f1 < 0) f1 = i; end
            if (pok2) begin c2++; if (f2 < 0) f2 = i; end
            if (pok2 && !pok1) bad = 1'b1;
            if (i == hold) pg = 1'b0;
        end
        exp2 = (hold > NS) ? hold - NS : 0;
        chk(f1 == 3, "R6 first power-OK rise cycle", f1, 3);
        chk(c1 == hold, "R8 first power-OK high cycles", c1, hold);
        chk(c2 == exp2, "R7 R8 second power-OK high cycles", c2, exp2);
        chk(!bad, "R7 second without first", int'(bad), 0);
        if (exp2 > 0)
            chk(f2 == NS + 3, "R7 second power-OK rise cycle", f2, NS + 3);
    endtask

    initial begin
        // R1 reset state
        idle(3);
        chk(btn_n == 1'b1 && pok1 == 1'b0 && pok2 == 1'b0 && en == 1'b0,
            "R1 outputs during reset", {btn_n, pok1, pok2, en}, 4'b1000);
        rst_n = 1'b1;
        idle(1);
        chk(btn_n == 1'b1 && pok1 == 1'b0 && pok2 == 1'b0 && en == 1'b0,
            "R1 outputs after reset", {btn_n, pok1, pok2, en}, 4'b1000);
        idle(4);

        // R3 R4 R5 sweep over press lengths
        for (int len = 1; len <= NC + 4; len++) begin
            press_run(len);
            idle(3);
        end

        // R6 R7 R8 sweep over power-good hold lengths
        for (int h = 1; h <= NS + 5; h++) begin
            pg_run(h);
            idle(3);
        end

        // R9 stagger restart
        begin
            int f2 = -1;
            @(negedge clk);
            pg = 1'b1;
            idle(6);
            pg = 1'b0;
            idle(2);
            pg = 1'b1;
            for (int i = 1; i <= NS + 10; i++) begin
                @(negedge clk);
                if (pok2 && f2 < 0) f2 = i;
            end
            chk(f2 == NS + 3, "R9 stagger restarted after drop", f2, NS + 3);
        end

        // R10 force-low override
        begin
            int f1 = -1, f2 = -1;
            bit leak = 1'b0;
            chk(pok2 == 1'b1, "R10 precondition both high", int'(pok2), 1);
            force_off = 1'b1;
            for (int i = 1; i <= 20; i++) begin
                @(negedge clk);
                if (i == 2) chk(pok1 == 1'b1, "R10 R2 still high before sync", int'(pok1), 1);
                if (i >= 3 && (pok1 || pok2)) leak = 1'b1;
            end
            chk(!leak, "R10 outputs held low by force", int'(leak), 0);
            force_off = 1'b0;
            for (int i = 1; i <= NS + 10; i++) begin
                @(negedge clk);
                if (pok1 && f1 < 0) f1 = i;
                if (pok2 && f2 < 0) f2 = i;
            end
            chk(f1 == 3, "R10 first power-OK after force release", f1, 3);
            chk(f2 == NS + 3, "R10 second power-OK after force release", f2, NS + 3);
            pg = 1'b0;
            idle(5);
        end

        // R11 enable pulse on platform reset rise, none on fall
        for (int rep = 0; rep < 2; rep++) begin
            int pulses = 0, at = -1;
            prst_n = 1'b1;
            for (int i = 1; i <= 10; i++) begin
                @(negedge clk);
                if (en) begin pulses++; at = i; end
            end
            chk(pulses == 1, "R11 one pulse per rise", pulses, 1);
            chk(at == 3, "R11 R2 pulse cycle", at, 3);
            pulses = 0;
            prst_n = 1'b0;
            for (int i = 1; i <= 10; i++) begin
                @(negedge clk);
                if (en) pulses++;
            end
            chk(pulses == 0, "R11 no pulse on fall", pulses, 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule